// File: doc/BRIEF.md
# Card Command Response Capture Engine

This block starts one command on a memory card link. Software loads a 6-bit command index and a 32-bit argument; the argument is written as two 16-bit halves. A launch pulse then starts the command, together with a 2-bit response-type code and a data-phase enable. The engine offers the index and argument to the card-side logic through a valid/ready handshake. After the card side accepts them, the engine collects the response as a byte stream. The card side marks the final byte with an end strobe.

Response bytes are packed in pairs into a nine-entry halfword store. Byte 2i forms the low half of entry i and byte 2i+1 forms the high half. The store is zeroed at every launch. When the response is shorter than its type requires, the engine raises a response-timeout status bit. When the response is long enough, it raises a response-complete status bit and rewinds the read pointer of the store. It then either finishes or pulses a hand-off to the data engine. A one-cycle end-of-command pulse marks the end of every command, whatever the outcome. Software pops the store one halfword per read.

Top module: `card_cmd_capture`

## Requirements
- R1: After reset the engine is idle (`busy`=0, `cmd_valid`=0), `status`, `end_cmd` and `data_start` are 0, a command-register read (`rd_sel`=0) returns 16'h0040 and a response read (`rd_sel`=3) returns 0.
- R2: Writes select the field with `wr_sel`: 0 sets the index (low 6 bits), 1 sets argument bits 31:16 and 2 sets bits 15:0, and each half-write keeps the other half. Reads use `rd_sel`: 0 returns the index with bit 6 set, 1 returns the high half and 2 returns the low half.
- R3: A `start` while idle raises `cmd_valid` on the next cycle. `cmd_valid` stays high until a cycle with `cmd_ready`. A `start` while busy is ignored, and the running command keeps its original response type.
- R4: Response type 0 finishes in the cycle in which the card side accepts the command. No response bytes are awaited, and status bit 13 is set.
- R5: Types 1 and 3 need at least 4 response bytes, and type 2 needs at least 16. The count includes a byte that arrives together with `rsp_end`. A shorter response sets status bit 1 (timeout) only. A long enough response sets status bit 13 only.
- R6: `end_cmd` pulses for exactly one cycle after every command, on success and on timeout, and `busy` is then low.
- R7: Halfword i of the store holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8.
- R8: Each response read returns the next halfword, up to 9. After 9 reads it returns 0. Entries that no received byte reached read 0, and bytes past the 18th are dropped.
- R9: `data_start` pulses together with `end_cmd` only when the command succeeded and the data enable was set at launch. It never pulses after a timeout.
- R10: A launch clears both status bits and zeroes the response store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 index, 1 arg high, 2 arg low |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (pops the store when `rd_sel`=3) |
| rd_sel | input | 2 | Read source: 0 command, 1 arg high, 2 arg low, 3 response |
| rd_data | output | 16 | Read data, combinational from `rd_sel` |
| start | input | 1 | Launch pulse |
| rtype | input | 2 | Response type code, sampled at launch |
| data_en | input | 1 | Data phase follows on success, sampled at launch |
| cmd_valid | output | 1 | Command offered to the card side |
| cmd_ready | input | 1 | Card side accepts the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response byte present |
| rsp_byte | input | 8 | Response byte |
| rsp_end | input | 1 | Response finished (may come with the last byte) |
| busy | output | 1 | Command in progress |
| end_cmd | output | 1 | One-cycle end-of-command pulse |
| data_start | output | 1 | One-cycle hand-off to the data engine |
| status | output | 16 | Bit 1 response timeout, bit 13 response complete |

## Verification
A wrong sequencer state appears at the ports within one cycle. Either `cmd_valid` drops before acceptance, or `busy` does not match the `end_cmd` pulse. An error in the byte counter or the length threshold shows up as the wrong status bit in the cycle after `rsp_end`. A fault in packing, clearing or the read pointer stays hidden until software reads the store. It then shows as a swapped byte, a stale value from an earlier command, or a non-zero value after the ninth read.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_COLLECT} seq_state_t;

  localparam int STAT_W       = 16;
  localparam int STAT_TOUT    = 1;
  localparam int STAT_RSPDONE = 13;
  localparam int CMD_FLAG_BIT = 6;

  localparam logic [1:0] SEL_INDEX = 2'd0;
  localparam logic [1:0] SEL_ARGHI = 2'd1;
  localparam logic [1:0] SEL_ARGLO = 2'd2;
  localparam logic [1:0] SEL_RESP  = 2'd3;

  // minimum byte count per response type
  function automatic int unsigned min_bytes(input logic [1:0] t);
    case (t)
      2'd0:    return 0;
      2'd2:    return 16;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/card_cmd_regs.sv
module card_cmd_regs #(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [HALF_W-1:0]   wr_data,
  output logic [IDX_W-1:0]    idx,
  output logic [2*HALF_W-1:0] arg
);
  import card_cmd_pkg::*;

  logic [IDX_W-1:0]    idx_d;
  logic [HALF_W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic                idx_en, hi_en, lo_en;

  assign idx_en = wr_en && (wr_sel == SEL_INDEX);
  assign hi_en  = wr_en && (wr_sel == SEL_ARGHI);
  assign lo_en  = wr_en && (wr_sel == SEL_ARGLO);

  always_comb begin
    idx_d = wr_data[IDX_W-1:0];
    hi_d  = wr_data;
    lo_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (idx_en) idx  <= idx_d;
      if (hi_en)  hi_q <= hi_d;
      if (lo_en)  lo_q <= lo_d;
    end
  end

  assign arg = {hi_q, lo_q};
endmodule

// File: rtl/card_resp_store.sv
module card_resp_store #(
  parameter int WORDS = 9,
  localparam int NBYTES = 2 * WORDS,
  localparam int CW = $clog2(NBYTES + 1),
  localparam int PW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap_en,
  input  logic [7:0]    cap_byte,
  input  logic          rewind,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [15:0]   rd_word
);
  logic [CW-1:0] cnt_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [15:0]   words [WORDS];

  always_comb begin
    cnt_d = count;
    if (clear) cnt_d = '0;
    else if (cap_en && (count < CW'(NBYTES))) cnt_d = count + 1'b1;
  end

  always_comb begin
    rptr_d = rptr_q;
    if (rewind) rptr_d = '0;
    else if (pop && (rptr_q < PW'(WORDS))) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rptr_q <= '0;
    end else begin
      count  <= cnt_d;
      rptr_q <= rptr_d;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 2; b++) begin : g_byte
      logic       en;
      logic [7:0] nxt;
      assign en = clear || (cap_en && (count == CW'(2 * w + b)));
      always_comb nxt = clear ? 8'h00 : cap_byte;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  words[w][8*b +: 8] <= 8'h00;
        else if (en) words[w][8*b +: 8] <= nxt;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (rptr_q == PW'(w)) rd_word = words[w];
  end
endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    rtype,
  input  logic          data_en,
  input  logic          cmd_ready,
  input  logic          rsp_valid,
  input  logic          rsp_end,
  input  logic [CW-1:0] count,
  output logic          busy,
  output logic          cmd_valid,
  output logic          clear,
  output logic          cap_en,
  output logic          rewind,
  output logic          end_cmd,
  output logic          data_start,
  output logic          stat_tout,
  output logic          stat_done
);
  import card_cmd_pkg::*;

  seq_state_t st_q, st_d;
  logic [1:0] rt_q;
  logic       den_q;
  logic       launch, finish, ok;
  logic [CW:0] total;
  logic       end_d, ds_d, tout_d, done_d;

  assign launch    = (st_q == ST_IDLE) && start;
  assign busy      = (st_q != ST_IDLE);
  assign cmd_valid = (st_q == ST_ISSUE);
  assign cap_en    = (st_q == ST_COLLECT) && rsp_valid;
  assign total     = {1'b0, count} + (CW+1)'(rsp_valid);

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    ok     = 1'b0;
    case (st_q)
      ST_IDLE:    if (start) st_d = ST_ISSUE;
      ST_ISSUE:   if (cmd_ready) begin
                    if (rt_q == 2'd0) begin
                      st_d = ST_IDLE; finish = 1'b1; ok = 1'b1;
                    end else st_d = ST_COLLECT;
                  end
      ST_COLLECT: if (rsp_end) begin
                    st_d   = ST_IDLE;
                    finish = 1'b1;
                    ok     = (32'(total) >= min_bytes(rt_q));
                  end
      default:    st_d = ST_IDLE;
    endcase
  end

  assign clear  = launch;
  assign rewind = finish && ok;

  always_comb begin
    end_d  = finish;
    ds_d   = finish && ok && den_q;
    tout_d = launch ? 1'b0 : (finish && !ok) ? 1'b1 : stat_tout;
    done_d = launch ? 1'b0 : (finish && ok)  ? 1'b1 : stat_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rt_q       <= '0;
      den_q      <= 1'b0;
      end_cmd    <= 1'b0;
      data_start <= 1'b0;
      stat_tout  <= 1'b0;
      stat_done  <= 1'b0;
    end else begin
      st_q       <= st_d;
      end_cmd    <= end_d;
      data_start <= ds_d;
      stat_tout  <= tout_d;
      stat_done  <= done_d;
      if (launch) begin
        rt_q  <= rtype;
        den_q <= data_en;
      end
    end
  end
endmodule

// File: rtl/card_cmd_capture.sv
module card_cmd_capture #(
  parameter int IDX_W  = 6,
  parameter int HALF_W = 16,
  parameter int WORDS  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [1:0]          rd_sel,
  output logic [HALF_W-1:0]   rd_data,
  input  logic                start,
  input  logic [1:0]          rtype,
  input  logic                data_en,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [IDX_W-1:0]    cmd_index,
  output logic [2*HALF_W-1:0] cmd_arg,
  input  logic                rsp_valid,
  input  logic [7:0]          rsp_byte,
  input  logic                rsp_end,
  output logic                busy,
  output logic                end_cmd,
  output logic                data_start,
  output logic [15:0]         status
);
  import card_cmd_pkg::*;

  localparam int CW = $clog2(2 * WORDS + 1);

  logic          clear, cap_en, rewind, pop, s_tout, s_done;
  logic [CW-1:0] count;
  logic [15:0]   rd_word;

  assign pop = rd_en && (rd_sel == SEL_RESP);

  card_cmd_regs #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .idx(cmd_index), .arg(cmd_arg)
  );

  card_resp_store #(.WORDS(WORDS)) u_store (
    .clk, .rst_n, .clear, .cap_en, .cap_byte(rsp_byte), .rewind, .pop,
    .count, .rd_word
  );

  card_cmd_seq #(.CW(CW)) u_seq (
    .clk, .rst_n, .start, .rtype, .data_en, .cmd_ready, .rsp_valid, .rsp_end,
    .count, .busy, .cmd_valid, .clear, .cap_en, .rewind, .end_cmd,
    .data_start, .stat_tout(s_tout), .stat_done(s_done)
  );

  always_comb begin
    status               = '0;
    status[STAT_TOUT]    = s_tout;
    status[STAT_RSPDONE] = s_done;
  end

  always_comb begin
    case (rd_sel)
      SEL_INDEX: begin
        rd_data = HALF_W'(cmd_index);
        rd_data[CMD_FLAG_BIT] = 1'b1;
      end
      SEL_ARGHI: rd_data = cmd_arg[2*HALF_W-1:HALF_W];
      SEL_ARGLO: rd_data = cmd_arg[HALF_W-1:0];
      default:   rd_data = HALF_W'(rd_word);
    endcase
  end
endmodule

// File: rtl/card_cmd_capture_chk.sv
module card_cmd_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        busy,
  input logic        end_cmd,
  input logic        data_start,
  input logic [15:0] status
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid); // R3
  AST_START_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> cmd_valid); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd |-> !busy); // R6
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_cmd |=> !end_cmd); // R6
  AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[13])); // R5
  AST_HANDOFF_OK: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> end_cmd && status[13]); // R9
  AST_TOUT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> !data_start); // R9
  AST_RESULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) || $rose(status[13]) |-> end_cmd); // R6
endmodule

bind card_cmd_capture card_cmd_capture_chk u_chk (
  .clk, .rst_n, .start, .cmd_valid, .cmd_ready, .busy, .end_cmd,
  .data_start, .status
);

// File: tb/card_cmd_capture_test.sv
module card_cmd_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, rd_en = 0, start = 0, data_en = 0;
  logic [1:0]  wr_sel = 0, rd_sel = 0, rtype = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        cmd_valid, cmd_ready = 0, rsp_valid = 0, rsp_end = 0;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [7:0]  rsp_byte = 0;
  logic        busy, end_cmd, data_start;
  logic [15:0] status;

  int checks = 0, fails = 0, cyc = 0;
  logic r_end, r_ds, r_busy;
  logic [15:0] r_stat;

  always #2 clk = ~clk;

  card_cmd_capture uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk); rd_sel = sel; rd_en = 1; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  // launch, hold off ready for dly cycles, then stream n bytes from base
  task automatic run_cmd(input logic [1:0] t, input logic de, input int n,
                         input logic [7:0] base, input int dly, input logic restart);
    @(negedge clk); start = 1; rtype = t; data_en = de;
    @(negedge clk); start = 0; rtype = 2'd2; data_en = 0;
    for (int i = 0; i < dly; i++) begin
      check("R3 valid held", cmd_valid, 1);
      if (restart && i == 0) start = 1;
      @(negedge clk); start = 0;
    end
    cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
    if (t != 2'd0) begin
      if (n == 0) begin
        rsp_end = 1; @(negedge clk); rsp_end = 0;
      end
      for (int i = 0; i < n; i++) begin
        rsp_valid = 1; rsp_byte = base + 8'(i); rsp_end = (i == n - 1);
        @(negedge clk);
      end
      rsp_valid = 0; rsp_end = 0;
    end
    r_end = end_cmd; r_ds = data_start; r_stat = status; r_busy = busy;
    @(negedge clk);
    check("R6 end pulse one cycle", end_cmd, 0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 busy", busy, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 status", status, 0);
    check("R1 end/data", {end_cmd, data_start}, 0);
    rd_reg(2'd0, v); check("R1 cmd read", v, 16'h0040);
    rd_reg(2'd3, v); check("R1 resp read", v, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr_reg(2'd0, 16'h002A); wr_reg(2'd1, 16'h1234); wr_reg(2'd2, 16'hBEEF);
    rd_reg(2'd0, v); check("R2 cmd read flag", v, 16'h006A);
    check("R2 arg out", cmd_arg, 32'h1234BEEF);
    wr_reg(2'd1, 16'h5555);
    rd_reg(2'd2, v); check("R2 low kept", v, 16'hBEEF);
    rd_reg(2'd1, v); check("R2 high", v, 16'h5555);
    wr_reg(2'd2, 16'h0001);
    check("R2 high kept", cmd_arg, 32'h55550001);
    check("R2 index out", cmd_index, 6'h2A);
  endtask

  task automatic t_type0;
    run_cmd(2'd0, 1'b0, 0, 8'h00, 3, 1'b0);
    check("R4 status done", r_stat, 16'h2000);
    check("R6 end on type0", r_end, 1);
    check("R9 no data when disabled", r_ds, 0);
    check("R6 idle at end", r_busy, 0);
  endtask

  task automatic t_short_type1_ok;
    logic [15:0] v;
    run_cmd(2'd1, 1'b1, 6, 8'h10, 1, 1'b0);
    check("R5 type1 six bytes ok", r_stat, 16'h2000);
    check("R9 data start", r_ds, 1);
    check("R6 end", r_end, 1);
    rd_reg(2'd3, v); check("R7 word0", v, 16'h1110);
    rd_reg(2'd3, v); check("R7 word1", v, 16'h1312);
    rd_reg(2'd3, v); check("R7 word2", v, 16'h1514);
    for (int i = 3; i < 9; i++) begin
      rd_reg(2'd3, v); check("R8 unfilled zero", v, 0);
    end
    rd_reg(2'd3, v); check("R8 exhausted zero", v, 0);
  endtask

  task automatic t_short;
    run_cmd(2'd3, 1'b1, 3, 8'h40, 0, 1'b0);
    check("R5 type3 three bytes timeout", r_stat, 16'h0002);
    check("R6 end on timeout", r_end, 1);
    check("R9 no data after timeout", r_ds, 0);
    run_cmd(2'd1, 1'b0, 4, 8'h50, 0, 1'b0);
    check("R5 type1 four bytes ok R10 cleared", r_stat, 16'h2000);
    run_cmd(2'd2, 1'b1, 15, 8'h60, 0, 1'b0);
    check("R5 type2 fifteen timeout", r_stat, 16'h0002);
    check("R9 no data type2 timeout", r_ds, 0);
  endtask

  task automatic t_long;
    logic [15:0] v;
    run_cmd(2'd2, 1'b0, 20, 8'h20, 0, 1'b0);
    check("R5 type2 ok R10 cleared", r_stat, 16'h2000);
    check("R9 no data flag", r_ds, 0);
    for (int i = 0; i < 9; i++) begin
      rd_reg(2'd3, v);
      check("R7 R8 packed word", v, {8'h21 + 8'(2*i), 8'h20 + 8'(2*i)});
    end
    rd_reg(2'd3, v); check("R8 tenth read zero, extra bytes dropped", v, 0);
    run_cmd(2'd0, 1'b0, 0, 8'h00, 0, 1'b0);
    rd_reg(2'd3, v); check("R10 store cleared at launch", v, 0);
  endtask

  task automatic t_busy_ignore;
    run_cmd(2'd1, 1'b0, 4, 8'h70, 2, 1'b1);
    check("R3 restart ignored keeps type1", r_stat, 16'h2000);
    check("R3 idle after", busy, 0);
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_type0();
    t_short_type1_ok();
    t_short();
    t_long();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule